// File: doc/BRIEF.md
# Alarm and Timer Interrupt Output Controller

This block produces a single active-low interrupt level for a real-time clock. Two sticky flags collect events. The alarm flag takes clock alarms, timer alarms and event-counter alarms. The timer flag takes timer overflows. The interrupt is asserted while a set flag has its interrupt enable at 1. A flag stays set until software writes a clear strobe for it, so the interrupt line stays asserted until that write.

When the block runs in clock mode with the alarm enable at 0, the output instead carries a free-running square wave. The wave is derived from a 100 Hz tick: the level inverts after every `HALF_TICKS` ticks, which gives 1 Hz at 50 % duty with the default setting. This wave can be used to calibrate the oscillator, and it is what the output shows after reset. Alarm comparison and the electrical driver stage are handled outside the block.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset `int_no` is 1 and both flags are 0. The wave counter is at 0 and the wave level is 1 (deasserted). A 0 on `int_no` means the interrupt is asserted.
- R2: When `clock_mode_i`=1 and `alarm_en_i`=0 (calibration), `int_no` equals the wave level. The level inverts on the clock edge that accepts every `HALF_TICKS`-th (default 50) pulse of `tick_100hz_i`. Both half periods are therefore equal in length. The wave keeps running in all modes.
- R3: With `alarm_en_i`=1, the alarm flag becomes 1 on the edge after any of these pulses: `tmr_alarm_i` in either mode, or `clk_alarm_i` while `clock_mode_i`=1. With `alarm_en_i`=0, all alarm source pulses are ignored.
- R4: A `tmr_ovf_i` pulse sets the timer flag on the next edge, whatever the mode and the alarm enable.
- R5: Each flag holds its value until its clear strobe (`alarm_clr_i` or `tmr_clr_i`) is sampled. It then reads 0 from the next cycle, unless a set arrives in the same cycle.
- R6: When a set source and the clear strobe of the same flag occur in the same cycle, the flag is 1 afterwards.
- R7: Outside calibration, `int_no` is 0 exactly when (alarm flag AND `alarm_irq_en_i`) OR (timer flag AND `tmr_irq_en_i`).
- R8: A flag set while its interrupt enable is 0 stays latched. `int_no` falls in the same cycle that the enable becomes 1, with no clock edge in between.
- R9: An asserted `int_no` stays 0 until the clear of the flag that caused it. It returns to 1 in the cycle after the clear strobe is sampled.
- R10: With `clock_mode_i`=0 (event counter mode), `evt_alarm_i` sets the alarm flag when `alarm_en_i`=1, `clk_alarm_i` is ignored, and the wave is never driven on `int_no`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_100hz_i | input | 1 | One-cycle pulse at 100 Hz |
| clock_mode_i | input | 1 | 1 = clock mode, 0 = event counter mode |
| alarm_en_i | input | 1 | Alarm enable bit; 0 in clock mode selects the calibration wave |
| clk_alarm_i | input | 1 | Clock alarm match pulse |
| tmr_alarm_i | input | 1 | Timer alarm match pulse |
| evt_alarm_i | input | 1 | Event counter alarm pulse |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| alarm_irq_en_i | input | 1 | Interrupt enable for the alarm flag |
| tmr_irq_en_i | input | 1 | Interrupt enable for the timer flag |
| alarm_clr_i | input | 1 | Software clear strobe for the alarm flag |
| tmr_clr_i | input | 1 | Software clear strobe for the timer flag |
| alarm_flag_o | output | 1 | Alarm flag state |
| tmr_flag_o | output | 1 | Timer flag state |
| int_no | output | 1 | Interrupt level, active low |

## Verification
The assertions check on every cycle:
- flag stickiness and clearing;
- set priority on a timer overflow;
- that disabled alarms cannot set the alarm flag;
- the interrupt level as a function of the flags and enables;
- that the calibration wave holds still between ticks.

Some behaviour only the bench scenarios can show, because it spans hundreds of cycles or depends on stimulus ordering:
- the wave's half-period length and its equal duty;
- mode-dependent filtering of the clock and event alarms;
- the same-cycle effect of raising an enable on a latched flag;
- the interrupt staying asserted over many cycles until the clear.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int unsigned DEF_HALF_TICKS = 50;
  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLG_ALARM = 0;
  localparam int unsigned FLG_TMR   = 1;

  typedef struct packed {
    logic clk_alarm;
    logic tmr_alarm;
    logic evt_alarm;
    logic tmr_ovf;
  } irq_src_t;

  typedef enum logic {
    MODE_EVENT = 1'b0,
    MODE_CLOCK = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/irq_cal_wave.sv
module irq_cal_wave #(
  parameter int unsigned HALF_TICKS = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic wave_o
);
  localparam int unsigned CW = (HALF_TICKS > 2) ? $clog2(HALF_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          wave_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wave_q <= 1'b1;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        wave_q <= ~wave_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign wave_o = wave_q;
endmodule

// File: rtl/irq_src_qual.sv
module irq_src_qual
  import alarm_irq_pkg::*;
(
  input  irq_src_t  src_i,
  input  cnt_mode_e mode_i,
  input  logic      alarm_en_i,
  output logic      alarm_set_o,
  output logic      tmr_set_o
);
  logic mode_alarm;

  // clock mode listens to clock alarms, event mode to event alarms
  always_comb begin
    unique case (mode_i)
      MODE_CLOCK: mode_alarm = src_i.clk_alarm;
      default:    mode_alarm = src_i.evt_alarm;
    endcase
  end

  assign alarm_set_o = alarm_en_i & (mode_alarm | src_i.tmr_alarm);
  assign tmr_set_o   = src_i.tmr_ovf;
endmodule

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set beats clear so no event is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int unsigned HALF_TICKS = DEF_HALF_TICKS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_100hz_i,
  input  logic clock_mode_i,
  input  logic alarm_en_i,
  input  logic clk_alarm_i,
  input  logic tmr_alarm_i,
  input  logic evt_alarm_i,
  input  logic tmr_ovf_i,
  input  logic alarm_irq_en_i,
  input  logic tmr_irq_en_i,
  input  logic alarm_clr_i,
  input  logic tmr_clr_i,
  output logic alarm_flag_o,
  output logic tmr_flag_o,
  output logic int_no
);
  irq_src_t             src;
  cnt_mode_e            mode;
  logic [NUM_FLAGS-1:0] set_v, clr_v, flag_v, ien_v;
  logic                 wave, cal_sel, req;

  assign src  = '{clk_alarm: clk_alarm_i, tmr_alarm: tmr_alarm_i,
                  evt_alarm: evt_alarm_i, tmr_ovf: tmr_ovf_i};
  assign mode = cnt_mode_e'(clock_mode_i);

  irq_src_qual u_qual (
    .src_i       (src),
    .mode_i      (mode),
    .alarm_en_i  (alarm_en_i),
    .alarm_set_o (set_v[FLG_ALARM]),
    .tmr_set_o   (set_v[FLG_TMR])
  );

  assign clr_v[FLG_ALARM] = alarm_clr_i;
  assign clr_v[FLG_TMR]   = tmr_clr_i;
  assign ien_v[FLG_ALARM] = alarm_irq_en_i;
  assign ien_v[FLG_TMR]   = tmr_irq_en_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    irq_sticky_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .flag_o (flag_v[g])
    );
  end

  irq_cal_wave #(.HALF_TICKS(HALF_TICKS)) u_wave (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_100hz_i),
    .wave_o (wave)
  );

  assign cal_sel = (mode == MODE_CLOCK) & ~alarm_en_i;
  assign req     = |(flag_v & ien_v);

  assign int_no       = cal_sel ? wave : ~req;
  assign alarm_flag_o = flag_v[FLG_ALARM];
  assign tmr_flag_o   = flag_v[FLG_TMR];
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_100hz_i,
  input logic clock_mode_i,
  input logic alarm_en_i,
  input logic clk_alarm_i,
  input logic tmr_alarm_i,
  input logic evt_alarm_i,
  input logic tmr_ovf_i,
  input logic alarm_irq_en_i,
  input logic tmr_irq_en_i,
  input logic alarm_clr_i,
  input logic tmr_clr_i,
  input logic alarm_flag_o,
  input logic tmr_flag_o,
  input logic int_no
);
  logic cal;
  assign cal = clock_mode_i & ~alarm_en_i;

  AST_ALARM_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_flag_o && !alarm_clr_i) |=> alarm_flag_o); // R5
  AST_TMR_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_flag_o && !tmr_clr_i) |=> tmr_flag_o); // R5
  AST_TMR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_clr_i && !tmr_ovf_i) |=> !tmr_flag_o); // R9
  AST_OVF_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_ovf_i |=> tmr_flag_o); // R6
  AST_ALARM_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alarm_en_i && !alarm_flag_o) |=> !alarm_flag_o); // R3
  AST_ALARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_clr_i && !alarm_en_i) |=> !alarm_flag_o); // R5
  AST_INT_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal |-> (int_no == !((alarm_flag_o && alarm_irq_en_i) || (tmr_flag_o && tmr_irq_en_i)))); // R7
  AST_WAVE_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal && !tick_100hz_i) |=> (!cal || $stable(int_no))); // R2
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk u_chk (.*);

// File: tb/alarm_irq_ctrl_test.sv
`timescale 1ns/1ps
module alarm_irq_ctrl_test;
  localparam int HALF = 50;
  localparam int TICK_DIV = 4;

  logic clk = 0, rst_n = 0;
  logic tick = 0, cmode = 1, aen = 0;
  logic ca = 0, ta = 0, ea = 0, ovf = 0;
  logic aie = 0, tie = 0, aclr = 0, tclr = 0;
  logic aflag, tflag, int_n;

  int total = 0, bad = 0;
  bit done = 0;

  alarm_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_100hz_i(tick), .clock_mode_i(cmode),
    .alarm_en_i(aen), .clk_alarm_i(ca), .tmr_alarm_i(ta), .evt_alarm_i(ea),
    .tmr_ovf_i(ovf), .alarm_irq_en_i(aie), .tmr_irq_en_i(tie),
    .alarm_clr_i(aclr), .tmr_clr_i(tclr), .alarm_flag_o(aflag),
    .tmr_flag_o(tflag), .int_no(int_n)
  );

  always #5 clk = ~clk;

  // tick generator, driven on falling edges
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TICK_DIV;
    tick <= (tdiv == 0);
  end

  // behavioural reference model
  bit m_af, m_tf, m_sq;
  int m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_af = 0; m_tf = 0; m_sq = 1; m_cnt = 0;
    end else begin
      bit aset;
      aset = aen && ((cmode && ca) || ta || (!cmode && ea));
      if (aset) m_af = 1; else if (aclr) m_af = 0;
      if (ovf) m_tf = 1; else if (tclr) m_tf = 0;
      if (tick) begin
        if (m_cnt == HALF - 1) begin m_cnt = 0; m_sq = !m_sq; end
        else m_cnt++;
      end
    end
  end

  function automatic bit exp_int();
    if (cmode && !aen) return m_sq;
    return !((m_af && aie) || (m_tf && tie));
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check((cmode && !aen) ? "R2 wave" : "R7 int", int_n, exp_int());
      check("R5 alarm flag", aflag, m_af);
      check("R5 timer flag", tflag, m_tf);
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  int t0, t1, t2;
  initial begin
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    check("R1 int after reset", int_n, 1);
    check("R1 alarm flag reset", aflag, 0);
    check("R1 timer flag reset", tflag, 0);

    // R2: measure both half periods
    t0 = 0;
    for (int i = 0; i < 2000 && int_n == 1; i++) @(negedge clk);
    t0 = $time;
    for (int i = 0; i < 2000 && int_n == 0; i++) @(negedge clk);
    t1 = $time;
    for (int i = 0; i < 2000 && int_n == 1; i++) @(negedge clk);
    t2 = $time;
    check("R2 low half", (t1 - t0) / 10, HALF * TICK_DIV);
    check("R2 high half", (t2 - t1) / 10, HALF * TICK_DIV);

    // R3: clock alarm in clock mode
    aen = 1; aie = 0;
    ca = 1; @(negedge clk); ca = 0;
    check("R3 clock alarm sets", aflag, 1);
    aclr = 1; @(negedge clk); aclr = 0;
    check("R5 alarm clear", aflag, 0);
    // R3: disabled alarm ignored
    aen = 0; ta = 1; ca = 1; @(negedge clk); ta = 0; ca = 0;
    check("R3 disabled alarm ignored", aflag, 0);
    aen = 1; ta = 1; @(negedge clk); ta = 0;
    check("R3 timer alarm sets", aflag, 1);
    aclr = 1; @(negedge clk); aclr = 0;

    // R10: event mode
    cmode = 0; aen = 0;
    cyc(2 * HALF * TICK_DIV + 5);
    check("R10 no wave in event mode", int_n, 1);
    aen = 1; ca = 1; @(negedge clk); ca = 0;
    check("R10 clock alarm ignored", aflag, 0);
    ea = 1; @(negedge clk); ea = 0;
    check("R10 event alarm sets", aflag, 1);

    // R4: overflow with alarms off
    aen = 0; ovf = 1; @(negedge clk); ovf = 0;
    check("R4 overflow sets", tflag, 1);
    // R6: set wins over clear
    ovf = 1; tclr = 1; @(negedge clk); ovf = 0; tclr = 0;
    check("R6 set wins", tflag, 1);
    cyc(10);
    check("R5 timer flag sticky", tflag, 1);
    check("R8 int high while disabled", int_n, 1);
    // R8: enable raises interrupt in same cycle
    tie = 1; #1;
    check("R8 int low on enable", int_n, 0);
    cyc(8);
    check("R9 int held", int_n, 0);
    tclr = 1; #1;
    check("R9 int low during clear", int_n, 0);
    @(negedge clk); tclr = 0;
    check("R9 int released", int_n, 1);
    // alarm flag still set from event mode
    aie = 1; #1;
    check("R7 alarm int", int_n, 0);
    aclr = 1; @(negedge clk); aclr = 0;
    check("R7 alarm int released", int_n, 1);
    aie = 0; tie = 0;
    cyc(5);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule